// File: doc/BRIEF.md
# Heartbeat Period Extender

This block lets a short hardware watchdog period stand in for a much longer heartbeat. Each core's hardware watchdog raises an interrupt once per period. The extender answers each interrupt with a poke that restarts that core's watchdog. While countdown mode is on, each answer also takes one from that core's countdown. When a core's countdown is already zero, the interrupt is left unanswered and the core is masked. From then on its hardware watchdog escalates through its NMI and reset stages, and these use the last two periods of the heartbeat.

The countdown reload value comes from a requested heartbeat in whole seconds. The period is the largest whole number of seconds, no greater than the hardware maximum, that divides the heartbeat exactly. The number of periods is the heartbeat divided by that period. The reload is that number less two, and never below zero.

A keepalive ping pokes every core and reloads every countdown. It also unmasks any masked core when the reload is nonzero or countdown mode is off. Loading a new heartbeat, starting countdown mode and stopping countdown mode each include a ping. All control inputs are single-cycle pulses. All outputs are registered.

Top module: `hbx_heartbeat_ext`

## Requirements
- R1: After reset, poke, masked and mode_active are all zero, and reload_value, period_value and every countdown are zero.
- R2: With countdown mode on, an interrupt from an unmasked core whose countdown is above zero raises that core's poke bit in the next cycle and lowers its countdown by one.
- R3: With countdown mode on, an interrupt from an unmasked core whose countdown is zero gives no poke, and it sets that core's masked bit. Further interrupts from a masked core give no poke and leave its countdown unchanged.
- R4: With countdown mode off, every interrupt from an unmasked core gives a poke in the next cycle, and the countdown and masked bits stay unchanged.
- R5: On cfg_load, period_value becomes the largest p in 1..MAX_PERIOD with cfg_heartbeat mod p equal to 0. With n = cfg_heartbeat / p, reload_value becomes n-2 when n > 2 and 0 otherwise. A heartbeat of 0 gives p = MAX_PERIOD and reload 0.
- R6: A ping pokes all cores in the next cycle and loads every countdown with the reload value. It clears a core's masked bit only when the reload is nonzero or countdown mode is off.
- R7: start performs a ping under the mode held before it and then sets mode_active. stop clears mode_active first and then performs a ping, which therefore always unmasks. When start and stop arrive together, stop wins.
- R8: cfg_load also performs a ping that uses the newly computed reload value.
- R9: Interrupts from several cores in the same cycle are each handled independently in that cycle.
- R10: A ping in the same cycle as an interrupt wins. The countdown is reloaded and not lowered, and the core is poked.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| start | input | 1 | Pulse: ping, then enable countdown mode |
| stop | input | 1 | Pulse: disable countdown mode, then ping |
| ping | input | 1 | Pulse: keepalive ping to all cores |
| cfg_load | input | 1 | Pulse: compute period and reload from cfg_heartbeat, then ping |
| cfg_heartbeat | input | HB_W | Requested heartbeat in seconds |
| wd_irq | input | N_CORES | Per-core watchdog interrupt, one bit per core |
| poke | output | N_CORES | Per-core watchdog restart pulse |
| masked | output | N_CORES | Per-core flag: servicing halted |
| count_out | output | N_CORES*HB_W | Countdowns, core i at bits [i*HB_W +: HB_W] |
| mode_active | output | 1 | Countdown mode on |
| reload_value | output | HB_W | Latched countdown reload |
| period_value | output | $clog2(MAX_PERIOD+1) | Latched period in seconds |

## Verification
Assertions inside each core slot check every cycle that a masked core is never poked without a ping. They also check that a ping always reloads the countdown and pokes, and that a serviced interrupt lowers the count by exactly one or, with mode off, leaves it alone. The top checks that stop always wins over start. Whether the period and reload arithmetic is right for a given heartbeat shows only in the bench's sweep over heartbeat values. The same holds for the full sequence of pokes before a core is masked, for the rule that decides whether a ping unmasks, and for independent handling across cores.

// File: rtl/hbx_pkg.sv
package hbx_pkg;
  typedef enum logic [2:0] {
    ACT_IDLE,
    ACT_RELOAD,
    ACT_POKE,
    ACT_COUNT,
    ACT_HALT
  } slot_act_e;
endpackage

// File: rtl/hbx_reload_calc.sv
module hbx_reload_calc #(
  parameter int HB_W       = 8,
  parameter int MAX_PERIOD = 5,
  parameter int PER_W      = $clog2(MAX_PERIOD + 1)
) (
  input  logic [HB_W-1:0]  heartbeat,
  output logic [PER_W-1:0] period,
  output logic [HB_W-1:0]  reload
);
  logic [MAX_PERIOD:1] fits;
  logic [HB_W-1:0]     quot [MAX_PERIOD:1];
  logic [HB_W-1:0]     nper;

  // One constant divider per candidate period
  for (genvar p = 1; p <= MAX_PERIOD; p++) begin : g_cand
    assign fits[p] = (heartbeat % HB_W'(p)) == '0;
    assign quot[p] = heartbeat / HB_W'(p);
  end

  // Largest fitting candidate wins; candidate 1 always fits
  always_comb begin
    period = PER_W'(1);
    nper   = quot[1];
    for (int p = 2; p <= MAX_PERIOD; p++) begin
      if (fits[p]) begin
        period = PER_W'(p);
        nper   = quot[p];
      end
    end
  end

  // Two final periods belong to the hardware escalation stages
  assign reload = (nper > HB_W'(2)) ? nper - HB_W'(2) : '0;
endmodule

// File: rtl/hbx_core_slot.sv
module hbx_core_slot
  import hbx_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             irq,
  input  logic             ping,
  input  logic             mode,
  input  logic             unmask_ok,
  input  logic [CNT_W-1:0] reload,
  output logic             poke,
  output logic             masked,
  output logic [CNT_W-1:0] count
);
  slot_act_e act;
  logic [CNT_W-1:0] cnt_q;
  logic masked_q, poke_q;

  always_comb begin
    act = ACT_IDLE;
    if (ping)                       act = ACT_RELOAD;
    else if (irq && !masked_q) begin
      if (!mode)                    act = ACT_POKE;
      else if (cnt_q != '0)         act = ACT_COUNT;
      else                          act = ACT_HALT;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      cnt_q    <= '0;
      masked_q <= 1'b0;
      poke_q   <= 1'b0;
    end else begin
      poke_q <= (act == ACT_RELOAD) || (act == ACT_POKE) || (act == ACT_COUNT);
      case (act)
        ACT_RELOAD: begin
          cnt_q <= reload;
          if (unmask_ok) masked_q <= 1'b0;
        end
        ACT_COUNT: cnt_q    <= cnt_q - CNT_W'(1);
        ACT_HALT:  masked_q <= 1'b1;
        default: ;
      endcase
    end
  end

  assign poke   = poke_q;
  assign masked = masked_q;
  assign count  = cnt_q;

  a_r3_masked_silent: assert property (@(posedge clk) disable iff (!rst_n)
    masked_q && !ping |=> !poke_q && $stable(cnt_q));
  a_r6_ping_reloads: assert property (@(posedge clk) disable iff (!rst_n)
    ping |=> poke_q && cnt_q == $past(reload));
  a_r2_count_down: assert property (@(posedge clk) disable iff (!rst_n)
    !ping && irq && !masked_q && mode && cnt_q != '0 |=> poke_q && cnt_q == $past(cnt_q) - CNT_W'(1));
  a_r3_halt_masks: assert property (@(posedge clk) disable iff (!rst_n)
    !ping && irq && !masked_q && mode && cnt_q == '0 |=> masked_q && !poke_q);
  a_r4_free_poke: assert property (@(posedge clk) disable iff (!rst_n)
    !ping && irq && !masked_q && !mode |=> poke_q && $stable(cnt_q) && !masked_q);
endmodule

// File: rtl/hbx_heartbeat_ext.sv
module hbx_heartbeat_ext #(
  parameter int N_CORES    = 4,
  parameter int HB_W       = 8,
  parameter int MAX_PERIOD = 5,
  localparam int PER_W     = $clog2(MAX_PERIOD + 1)
) (
  input  logic                    clk,
  input  logic                    rst_n,
  input  logic                    start,
  input  logic                    stop,
  input  logic                    ping,
  input  logic                    cfg_load,
  input  logic [HB_W-1:0]         cfg_heartbeat,
  input  logic [N_CORES-1:0]      wd_irq,
  output logic [N_CORES-1:0]      poke,
  output logic [N_CORES-1:0]      masked,
  output logic [N_CORES*HB_W-1:0] count_out,
  output logic                    mode_active,
  output logic [HB_W-1:0]         reload_value,
  output logic [PER_W-1:0]        period_value
);
  logic             mode_q;
  logic [HB_W-1:0]  reload_q, calc_reload, reload_use;
  logic [PER_W-1:0] period_q, calc_period;
  logic             ping_all, mode_at_ping, unmask_ok;

  hbx_reload_calc #(.HB_W(HB_W), .MAX_PERIOD(MAX_PERIOD), .PER_W(PER_W)) u_calc (
    .heartbeat (cfg_heartbeat),
    .period    (calc_period),
    .reload    (calc_reload)
  );

  assign ping_all     = ping | start | stop | cfg_load;
  assign reload_use   = cfg_load ? calc_reload : reload_q;
  assign mode_at_ping = stop ? 1'b0 : mode_q;
  assign unmask_ok    = (reload_use != '0) || !mode_at_ping;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q   <= 1'b0;
      reload_q <= '0;
      period_q <= '0;
    end else begin
      if (stop)       mode_q <= 1'b0;
      else if (start) mode_q <= 1'b1;
      if (cfg_load) begin
        reload_q <= calc_reload;
        period_q <= calc_period;
      end
    end
  end

  for (genvar i = 0; i < N_CORES; i++) begin : g_core
    hbx_core_slot #(.CNT_W(HB_W)) u_slot (
      .clk       (clk),
      .rst_n     (rst_n),
      .irq       (wd_irq[i]),
      .ping      (ping_all),
      .mode      (mode_q),
      .unmask_ok (unmask_ok),
      .reload    (reload_use),
      .poke      (poke[i]),
      .masked    (masked[i]),
      .count     (count_out[i*HB_W +: HB_W])
    );
  end

  assign mode_active  = mode_q;
  assign reload_value = reload_q;
  assign period_value = period_q;

  a_r7_stop_wins: assert property (@(posedge clk) disable iff (!rst_n)
    stop |=> !mode_active);
  a_r7_start_sets: assert property (@(posedge clk) disable iff (!rst_n)
    start && !stop |=> mode_active);
  a_r5_period_bounds: assert property (@(posedge clk) disable iff (!rst_n)
    cfg_load |=> period_value >= PER_W'(1) && period_value <= PER_W'(MAX_PERIOD));
  a_r6_ping_all: assert property (@(posedge clk) disable iff (!rst_n)
    ping |=> poke == {N_CORES{1'b1}});
endmodule

// File: tb/hbx_heartbeat_ext_test.sv
`timescale 1ns/1ps
module hbx_heartbeat_ext_test;
  localparam int N = 4, W = 8, MAXP = 5, PW = $clog2(MAXP + 1);

  logic clk = 0, rst_n = 0;
  logic start = 0, stop = 0, ping = 0, cfg_load = 0;
  logic [W-1:0] hb = 0;
  logic [N-1:0] irq = 0;
  logic [N-1:0] poke, masked;
  logic [N*W-1:0] cnt_bus;
  logic mode;
  logic [W-1:0] rld;
  logic [PW-1:0] per;
  int runs = 0, fails = 0;

  always #5 clk = ~clk;

  hbx_heartbeat_ext #(.N_CORES(N), .HB_W(W), .MAX_PERIOD(MAXP)) uut (
    .clk(clk), .rst_n(rst_n), .start(start), .stop(stop), .ping(ping),
    .cfg_load(cfg_load), .cfg_heartbeat(hb), .wd_irq(irq), .poke(poke),
    .masked(masked), .count_out(cnt_bus), .mode_active(mode),
    .reload_value(rld), .period_value(per));

  task automatic check(string tag, int act, int exp);
    runs++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  function automatic int cnt_of(int i);
    return int'(cnt_bus[i*W +: W]);
  endfunction

  function automatic int exp_period(int h);
    for (int p = MAXP; p >= 1; p--) if (h % p == 0) return p;
    return 1;
  endfunction

  function automatic int exp_reload(int h);
    int n = h / exp_period(h);
    return (n > 2) ? n - 2 : 0;
  endfunction

  // One cycle of stimulus; outputs reflect it on return
  task automatic op(logic st, logic sp, logic pg, logic cf, logic [N-1:0] ir, int h);
    @(negedge clk);
    start = st; stop = sp; ping = pg; cfg_load = cf; irq = ir; hb = W'(h);
    @(posedge clk); #1;
    start = 0; stop = 0; ping = 0; cfg_load = 0; irq = 0;
  endtask

  initial begin
    #2000000;
    fails++; runs++;
    $display("FAIL watchdog: actual 0 expected 1");
    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end

  initial begin
    int r;
    int hbs[5] = '{6, 20, 25, 3, 13};
    repeat (3) @(posedge clk);
    #1;
    // R1 reset state
    check("R1 poke", int'(poke), 0);
    check("R1 masked", int'(masked), 0);
    check("R1 mode", int'(mode), 0);
    check("R1 reload", int'(rld), 0);
    check("R1 period", int'(per), 0);
    check("R1 count", int'(cnt_bus), 0);
    @(negedge clk); rst_n = 1;

    // R5 / R8 sweep over heartbeats
    for (int h = 0; h <= 60; h++) begin
      op(0, 0, 0, 1, '0, h);
      check($sformatf("R5 period hb=%0d", h), int'(per), (h == 0) ? MAXP : exp_period(h));
      check($sformatf("R5 reload hb=%0d", h), int'(rld), exp_reload(h));
      check($sformatf("R8 count hb=%0d", h), cnt_of(3), exp_reload(h));
      check("R8 poke", int'(poke), 15);
    end

    // R4 mode off: every interrupt poked, no counting
    op(0, 0, 0, 1, '0, 25);
    for (int k = 0; k < 6; k++) begin
      op(0, 0, 0, 0, 4'hF, 0);
      check("R4 poke", int'(poke), 15);
      check("R4 count", cnt_of(1), 3);
      check("R4 masked", int'(masked), 0);
    end

    // R2 / R3 / R6 / R7 countdown per heartbeat
    foreach (hbs[j]) begin
      r = exp_reload(hbs[j]);
      op(0, 0, 0, 1, '0, hbs[j]);
      op(1, 0, 0, 0, '0, 0);
      check("R7 start sets mode", int'(mode), 1);
      for (int k = 0; k < r; k++) begin
        op(0, 0, 0, 0, 4'b0001, 0);
        check("R2 poke", int'(poke), 1);
        check("R2 count", cnt_of(0), r - k - 1);
      end
      op(0, 0, 0, 0, 4'b0001, 0);
      check("R3 no poke at zero", int'(poke), 0);
      check("R3 masked", int'(masked), 1);
      op(0, 0, 0, 0, 4'b0001, 0);
      check("R3 ignored poke", int'(poke), 0);
      check("R3 ignored count", cnt_of(0), 0);
      op(0, 0, 1, 0, '0, 0);
      check("R6 ping pokes", int'(poke), 15);
      check("R6 ping reloads", cnt_of(0), r);
      check("R6 unmask rule", int'(masked), (r != 0) ? 0 : 1);
      op(0, 0, 0, 0, 4'b0001, 0);
      check("R3/R6 after ping", int'(poke), (r != 0) ? 1 : 0);
      op(0, 1, 0, 0, '0, 0);
      check("R7 stop clears mode", int'(mode), 0);
      check("R7 stop unmasks", int'(masked), 0);
    end

    // R9 concurrent interrupts
    op(0, 0, 0, 1, '0, 25);
    op(1, 0, 0, 0, '0, 0);
    op(0, 0, 0, 0, 4'hF, 0);
    check("R9 poke all", int'(poke), 15);
    op(0, 0, 0, 0, 4'b0101, 0);
    check("R9 poke subset", int'(poke), 5);
    check("R9 core0", cnt_of(0), 1);
    check("R9 core1", cnt_of(1), 2);
    check("R9 core2", cnt_of(2), 1);
    check("R9 core3", cnt_of(3), 2);

    // R10 ping with interrupt
    op(0, 0, 1, 0, 4'hF, 0);
    check("R10 poke", int'(poke), 15);
    check("R10 core0 reloaded", cnt_of(0), 3);
    check("R10 core3 reloaded", cnt_of(3), 3);

    // R7 start while on with reload 0 keeps mask; start+stop -> stop wins
    op(0, 0, 0, 1, '0, 6);
    op(0, 0, 0, 0, 4'b0010, 0);
    check("R3 masked reload0", int'(masked), 2);
    op(1, 0, 0, 0, '0, 0);
    check("R7 start keeps mask", int'(masked), 2);
    op(1, 1, 0, 0, '0, 0);
    check("R7 stop wins", int'(mode), 0);
    check("R7 stop wins unmask", int'(masked), 0);

    $display("[TB] %0d tests run, %0d failed", runs, fails);
    $finish;
  end
endmodule